// File: doc/BRIEF.md
# Request-Acknowledge Window Monitor

This block is a synthesizable protocol monitor for a single request line and a single acknowledge line that share one clock. It sees a request or acknowledge only when the line rises, which means the line was low at the previous clock edge and high at the current one. Every acknowledge must be paired with a distinct earlier request. That request must still be unmatched and must have risen between one and `MAX_AGE` clock edges before (five by default). Several requests can be waiting at the same time.

When an acknowledge has no eligible partner, the monitor raises a one-cycle error pulse and sets a sticky error flag. It also reports how many requests are still unmatched and inside the window. The monitor keeps a short age history with one bit per age. An accepted acknowledge consumes the longest-waiting request. A request that passes the window without being matched is dropped, and it can no longer justify any acknowledge.

The monitor sits beside an interface and only observes it. It never drives the handshake. It does not check that every request eventually receives an acknowledge.

Top module: `ack_window_monitor`

## Requirements
- R1: Only a rising edge (low at the previous clock edge, high at this one) counts as an event. A line held high for several cycles produces exactly one event.
- R2: An acknowledge event whose unmatched request rose 1 to 5 clock edges earlier is accepted. No error is raised and the outstanding count drops by one.
- R3: A request event on the same clock edge as an acknowledge event cannot satisfy that acknowledge. If no older request is eligible, the acknowledge is an error.
- R4: A request that stays unmatched for 5 edges leaves the window and is removed from the count. An acknowledge 6 or more edges after it is an error.
- R5: Pairing is one-to-one. A request already consumed by one acknowledge cannot justify a second one.
- R6: With several requests outstanding, an accepted acknowledge consumes the oldest eligible request.
- R7: The `outstanding` output equals the number of unmatched requests inside the window. It increments on each request event, and it updates on the clock edge that sees the event.
- R8: An acknowledge event while the outstanding count is zero is an error, and the count stays at zero.
- R9: A rejected acknowledge raises `err_pulse` for exactly the one cycle after the offending edge and sets `err_sticky`. Only reset clears `err_sticky`.
- R10: Synchronous reset clears the age history, the count, the edge history, `err_pulse` and `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request line being monitored |
| ack | input | 1 | Acknowledge line being monitored |
| err_pulse | output | 1 | High for one cycle after a rejected acknowledge |
| err_sticky | output | 1 | Set by any rejected acknowledge; cleared only by reset |
| outstanding | output | CNT_W (3 by default) | Number of unmatched requests still in the window |

## Verification
The bench places an acknowledge at every distance from 0 to 6 edges after a lone request. This separates the excluded same-edge case, the five accepted ages and the expired age. A second acknowledge after a single request shows whether a request can be consumed twice. Two staggered requests followed by two acknowledges show which request is consumed first, because a design that consumes the newest request strands the older one until it expires. Lines held high for several cycles and seeded random traffic with occasional resets exercise rising-edge detection and count bookkeeping, all compared against a queue of request timestamps kept by the bench.

// File: rtl/ackwin_pkg.sv
package ackwin_pkg;

  // Outcome of one clock edge as decided by the age tracker.
  typedef struct packed {
    logic accept;  // acknowledge matched an eligible request
    logic reject;  // acknowledge found nothing to match
    logic expire;  // an unmatched request left the window
  } ackwin_verdict_t;

endpackage

// File: rtl/ackwin_edge.sv
module ackwin_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ackwin_age_track.sv
module ackwin_age_track
  import ackwin_pkg::*;
#(
  parameter int MAX_AGE = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_ev,
  input  logic                 ack_ev,
  output ackwin_verdict_t      verdict,
  output logic [MAX_AGE-1:0]   window
);

  // window[k-1] set: an unmatched request rose k edges ago (k = 1..MAX_AGE).
  // Age 0 is the current req_ev, which is never eligible.
  logic [MAX_AGE-1:0] hist_q, hist_d, hist_cl, oldest;
  logic               any_elig;

  // One-hot of the highest set bit, i.e. the oldest waiting request.
  function automatic logic [MAX_AGE-1:0] pick_oldest(input logic [MAX_AGE-1:0] v);
    logic [MAX_AGE-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_AGE; i++) begin
      if (v[i]) r = MAX_AGE'(1) << i;
    end
    return r;
  endfunction

  assign any_elig = |hist_q;
  assign oldest   = pick_oldest(hist_q);

  always_comb begin
    verdict.accept = ack_ev & any_elig;
    verdict.reject = ack_ev & ~any_elig;
    hist_cl        = verdict.accept ? (hist_q & ~oldest) : hist_q;
    verdict.expire = hist_cl[MAX_AGE-1];
  end

  generate
    if (MAX_AGE == 1) begin : g_single
      always_comb hist_d = req_ev;
    end else begin : g_shift
      always_comb hist_d = {hist_cl[MAX_AGE-2:0], req_ev};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= hist_d;
  end

  assign window = hist_q;

  // R6
  oldest_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oldest));

  // R3
  fresh_req_lands_age1_chk: assert property (@(posedge clk) disable iff (rst)
    req_ev |=> window[0]);

endmodule

// File: rtl/ackwin_count.sv
module ackwin_count #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             drop,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c, input logic up, input logic dn, input logic gone);
    return c + CNT_W'(up) - CNT_W'(dn) - CNT_W'(gone);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= step_count(count_q, inc, dec, drop);
  end

  assign count = count_q;

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> !(dec || drop));

endmodule

// File: rtl/ack_window_monitor.sv
module ack_window_monitor
  import ackwin_pkg::*;
#(
  parameter int MAX_AGE = 5,
  localparam int CNT_W  = $clog2(MAX_AGE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             ack,
  output logic             err_pulse,
  output logic             err_sticky,
  output logic [CNT_W-1:0] outstanding
);

  logic               req_ev, ack_ev;
  ackwin_verdict_t    verdict;
  logic [MAX_AGE-1:0] window;
  logic               pulse_q, sticky_q;

  ackwin_edge u_req_edge (.clk(clk), .rst(rst), .lvl(req), .rise(req_ev));
  ackwin_edge u_ack_edge (.clk(clk), .rst(rst), .lvl(ack), .rise(ack_ev));

  ackwin_age_track #(.MAX_AGE(MAX_AGE)) u_track (
    .clk(clk), .rst(rst), .req_ev(req_ev), .ack_ev(ack_ev),
    .verdict(verdict), .window(window)
  );

  ackwin_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .inc(req_ev), .dec(verdict.accept),
    .drop(verdict.expire), .count(outstanding)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      pulse_q  <= verdict.reject;
      sticky_q <= sticky_q | verdict.reject;
    end
  end

  assign err_pulse  = pulse_q;
  assign err_sticky = sticky_q;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  // R9
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_sticky);

  // R8
  zero_count_ack_err_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ev && outstanding == '0) |=> err_pulse);

  // R2
  eligible_ack_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ev && |window) |=> !err_pulse);

  // R7
  count_tracks_window_chk: assert property (@(posedge clk) disable iff (rst)
    int'(outstanding) == $countones(window));

endmodule

// File: tb/ack_window_monitor_tb.sv
`timescale 1ns/1ps
module ack_window_monitor_tb;

  localparam int WIN = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       ack = 1'b0;
  logic       err_pulse, err_sticky;
  logic [2:0] outstanding;

  int total = 0;
  int bad   = 0;

  // bench model: timestamps of unmatched requests, oldest first
  int q[$];
  int tnow = 0;
  bit m_pr = 0, m_pa = 0, m_pulse = 0, m_sticky = 0;

  always #2.5 clk = ~clk;

  ack_window_monitor u_dut (
    .clk(clk), .rst(rst), .req(req), .ack(ack),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .outstanding(outstanding)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0d)", tag, what, act, exp, tnow);
    end
  endtask

  // model of one clock edge, from the requirements
  function automatic void model_edge(input bit r, input bit a, input bit rs);
    bit rev, aev;
    tnow++;
    if (rs) begin
      q.delete(); m_pr = 0; m_pa = 0; m_pulse = 0; m_sticky = 0;
      return;
    end
    rev = r && !m_pr;
    aev = a && !m_pa;
    m_pr = r; m_pa = a;
    m_pulse = 0;
    if (aev) begin
      if (q.size() > 0) void'(q.pop_front());
      else m_pulse = 1;
    end
    if (rev) q.push_back(tnow);
    while (q.size() > 0 && tnow - q[0] >= WIN) void'(q.pop_front());
    m_sticky = m_sticky | m_pulse;
  endfunction

  task automatic step(input bit r, input bit a, input string tag, input bit rs = 0);
    req = r; ack = a; rst = rs;
    @(posedge clk);
    model_edge(r, a, rs);
    #1;
    chk(tag, int'(outstanding), q.size(), "outstanding");
    chk(tag, int'(err_pulse), int'(m_pulse), "err_pulse");
    chk(tag, int'(err_sticky), int'(m_sticky), "err_sticky");
  endtask

  task automatic do_reset();
    step(0, 0, "R10", 1);
    step(0, 0, "R10", 1);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    // R10 reset state
    do_reset();
    chk("R10", int'(err_sticky), 0, "sticky after reset");
    chk("R10", int'(outstanding), 0, "count after reset");

    // R2 / R3 / R4: ack at distance d after a lone request
    for (int d = 0; d <= 6; d++) begin
      do_reset();
      if (d == 0) step(1, 1, "R3");
      else begin
        step(1, 0, "R7");
        chk("R7", int'(outstanding), 1, "count after req");
        for (int k = 1; k < d; k++) step(0, 0, "R4");
        step(0, 1, (d == 6) ? "R4" : "R2");
      end
      chk((d == 0) ? "R3" : (d == 6) ? "R4" : "R2", int'(err_pulse),
          (d == 0 || d == 6) ? 1 : 0, "pulse by distance");
      step(0, 0, "R9");
      chk("R9", int'(err_pulse), 0, "pulse lasts one cycle");
    end

    // R4 expiry lowers the count after 5 edges
    do_reset();
    step(1, 0, "R4");
    for (int k = 1; k < 5; k++) step(0, 0, "R4");
    chk("R4", int'(outstanding), 1, "count at age 4");
    step(0, 0, "R4");
    chk("R4", int'(outstanding), 0, "count after expiry");

    // R5 one request, two acknowledges
    do_reset();
    step(1, 0, "R5"); step(0, 1, "R5"); step(0, 0, "R5"); step(0, 1, "R5");
    chk("R5", int'(err_pulse), 1, "second ack rejected");

    // R6 oldest consumed first
    do_reset();
    step(1, 0, "R6"); step(0, 0, "R6"); step(0, 0, "R6");
    step(1, 0, "R6"); step(0, 0, "R6");
    step(0, 1, "R6"); step(0, 0, "R6"); step(0, 0, "R6");
    step(0, 1, "R6");
    chk("R6", int'(err_sticky), 0, "oldest-first pairing");

    // R1 held lines give one event each
    do_reset();
    step(1, 0, "R1"); step(1, 0, "R1"); step(1, 0, "R1");
    chk("R1", int'(outstanding), 1, "held req counted once");
    step(0, 0, "R1"); step(1, 0, "R1");
    step(0, 1, "R1"); step(0, 1, "R1");
    chk("R1", int'(outstanding), 1, "held ack consumed once");

    // R8 ack with nothing outstanding; R9 sticky persists
    do_reset();
    step(0, 1, "R8");
    chk("R8", int'(err_pulse), 1, "ack at zero count");
    chk("R8", int'(outstanding), 0, "count stays zero");
    for (int k = 0; k < 4; k++) step(0, 0, "R9");
    chk("R9", int'(err_sticky), 1, "sticky held");
    do_reset();
    chk("R10", int'(err_sticky), 0, "sticky cleared by reset");

    // random traffic with occasional reset (R7 bookkeeping)
    for (int n = 0; n < 4000; n++) begin
      bit r, a, rs;
      r  = ($urandom % 3) == 0;
      a  = ($urandom % 4) == 0;
      rs = ($urandom % 400) == 0;
      step(r, a, "R7", rs);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule